// File: doc/BRIEF.md
# Symmetric Triangle-Carrier PWM Channel

This block is one channel of a pulse-width modulator whose carrier is a symmetric up-down triangle. The carrier comes from a signed accumulator. On every enabled clock the accumulator grows by twice a configured step. When it would go beyond the period, it is folded back by twice the period. The carrier is the magnitude of that accumulator. It therefore falls from the period to zero and rises back to the period, with a slope of twice the step per clock.

The duty command is not used directly. It is captured into an active compare register at two points only: when the accumulator folds at the carrier peak, and when the accumulator crosses from negative to zero or above at the carrier valley. Each capture raises a one-clock event pulse, which the surrounding logic can use as an interrupt. An action qualifier compares the active compare value with the carrier and drives two complementary pre-outputs. Dead-time insertion and fault shutdown are left to later stages.

Top module: `symm_pwm_timer`

## Requirements
- R1: While the active-low synchronous reset is sampled low, the accumulator takes the value minus period, so the carrier reads the period. The active compare register is 0, the event pulse is 0, preA is 0 and preB is 1.
- R2: On each enabled clock the accumulator increases by twice `step`. The carrier output always equals the absolute value of the accumulator.
- R3: When the increased accumulator is strictly greater than `period`, twice `period` is subtracted in the same clock. With `period` held constant since reset, the carrier never exceeds `period`.
- R4: `eventPulse` is 1 for exactly the clock that follows an enabled edge where the accumulator folded, or where it went from negative to zero or above. It is 0 after every other edge.
- R5: At each such event edge the active compare register captures `compareIn`. At all other edges it holds its value, whatever `compareIn` does.
- R6: If the active compare is greater than the carrier at a clock edge, then after that edge preA is 0 and preB is 1. If it is less, then preA is 1 and preB is 0.
- R7: If the active compare equals the carrier at a clock edge, preA and preB keep their values across that edge.
- R8: While `enable` is low, the accumulator and the active compare register hold, and `eventPulse` is 0.
- R9: preA and preB are never equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| enable | input | 1 | Lets the accumulator advance |
| period | input | PERIOD_W | Carrier peak value; change only under reset |
| step | input | STEP_W | Base step; the accumulator moves by twice this value |
| compareIn | input | PERIOD_W | Duty command, captured at carrier events |
| carrier | output | PERIOD_W | Magnitude of the accumulator |
| activeCompare | output | PERIOD_W | Compare value currently in use |
| eventPulse | output | 1 | One-clock pulse at peak fold or valley crossing |
| preA | output | 1 | Pre-output A |
| preB | output | 1 | Pre-output B, complement of A |

## Verification
The channel is driven with several period and step pairs. These include a period that is an exact multiple of twice the step, so the carrier lands on both zero and the peak; odd periods where the fold skips the peak; and steps large enough that the valley crossing lands above zero. The compare commands are zero, a value inside the range, a value equal to a reachable carrier level and a value above the period. Together they separate the greater, lesser and equal branches of the qualifier. A compare change made in mid-ramp shows that capture happens only at events. An enable-low window shows that the carrier, the compare register and the pulse all freeze.

// File: rtl/symm_pwm_pkg.sv
package symm_pwm_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic advance;
    logic loadCmp;
  } pwm_strobe_t;

  // carrier status from datapath to control
  typedef struct packed {
    logic foldHit;
    logic crossHit;
  } pwm_status_t;
endpackage

// File: rtl/symm_pwm_dp.sv
module symm_pwm_dp
  import symm_pwm_pkg::*;
#(
  parameter int PERIOD_W = 8,
  parameter int STEP_W   = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [PERIOD_W-1:0] period,
  input  logic [STEP_W-1:0]   step,
  input  logic [PERIOD_W-1:0] compareIn,
  input  pwm_strobe_t         strobe,
  output pwm_status_t         status,
  output logic [PERIOD_W-1:0] carrier,
  output logic [PERIOD_W-1:0] activeCompare
);
  // headroom: the sum may reach period + 2*step before folding
  localparam int ACC_W = PERIOD_W + 3;

  logic signed [ACC_W-1:0] accQ;
  logic signed [ACC_W-1:0] accSum;
  logic signed [ACC_W-1:0] accFold;
  logic signed [ACC_W-1:0] accNext;
  logic signed [ACC_W-1:0] periodS;
  logic signed [ACC_W-1:0] stepTwice;
  logic [PERIOD_W-1:0]     cmpQ;

  assign periodS   = $signed({{(ACC_W-PERIOD_W){1'b0}}, period});
  assign stepTwice = $signed({{(ACC_W-STEP_W-1){1'b0}}, step, 1'b0});

  assign accSum  = accQ + stepTwice;
  assign accFold = accSum - (periodS <<< 1);

  always_comb begin
    status.foldHit  = accSum > periodS;
    accNext         = status.foldHit ? accFold : accSum;
    status.crossHit = accQ[ACC_W-1] & ~accNext[ACC_W-1];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      accQ <= -periodS;
      cmpQ <= '0;
    end else begin
      if (strobe.advance) accQ <= accNext;
      if (strobe.loadCmp) cmpQ <= compareIn;
    end
  end

  assign carrier       = PERIOD_W'(accQ[ACC_W-1] ? -accQ : accQ);
  assign activeCompare = cmpQ;
endmodule

// File: rtl/symm_pwm_ctrl.sv
module symm_pwm_ctrl
  import symm_pwm_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        enable,
  input  pwm_status_t status,
  output pwm_strobe_t strobe,
  output logic        eventPulse
);
  logic eventQ;

  always_comb begin
    strobe.advance = enable;
    strobe.loadCmp = enable & (status.foldHit | status.crossHit);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) eventQ <= 1'b0;
    else        eventQ <= strobe.loadCmp;
  end

  assign eventPulse = eventQ;
endmodule

// File: rtl/symm_pwm_aq.sv
module symm_pwm_aq #(
  parameter int PERIOD_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [PERIOD_W-1:0] carrier,
  input  logic [PERIOD_W-1:0] compare,
  output logic                preA,
  output logic                preB
);
  logic aQ;

  always_ff @(posedge clk) begin
    if (!rst_n)                aQ <= 1'b0;
    else if (compare > carrier) aQ <= 1'b0;
    else if (compare < carrier) aQ <= 1'b1;
  end

  assign preA = aQ;
  assign preB = ~aQ;
endmodule

// File: rtl/symm_pwm_timer.sv
module symm_pwm_timer
  import symm_pwm_pkg::*;
#(
  parameter int PERIOD_W = 8,
  parameter int STEP_W   = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                enable,
  input  logic [PERIOD_W-1:0] period,
  input  logic [STEP_W-1:0]   step,
  input  logic [PERIOD_W-1:0] compareIn,
  output logic [PERIOD_W-1:0] carrier,
  output logic [PERIOD_W-1:0] activeCompare,
  output logic                eventPulse,
  output logic                preA,
  output logic                preB
);
  pwm_strobe_t strobe;
  pwm_status_t status;

  symm_pwm_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .status     (status),
    .strobe     (strobe),
    .eventPulse (eventPulse)
  );

  symm_pwm_dp #(.PERIOD_W(PERIOD_W), .STEP_W(STEP_W)) u_dp (
    .clk           (clk),
    .rst_n         (rst_n),
    .period        (period),
    .step          (step),
    .compareIn     (compareIn),
    .strobe        (strobe),
    .status        (status),
    .carrier       (carrier),
    .activeCompare (activeCompare)
  );

  symm_pwm_aq #(.PERIOD_W(PERIOD_W)) u_aq (
    .clk     (clk),
    .rst_n   (rst_n),
    .carrier (carrier),
    .compare (activeCompare),
    .preA    (preA),
    .preB    (preB)
  );
endmodule

// File: rtl/symm_pwm_timer_chk.sv
module symm_pwm_timer_chk #(
  parameter int PERIOD_W = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                enable,
  input logic [PERIOD_W-1:0] period,
  input logic [PERIOD_W-1:0] compareIn,
  input logic [PERIOD_W-1:0] carrier,
  input logic [PERIOD_W-1:0] activeCompare,
  input logic                eventPulse,
  input logic                preA,
  input logic                preB
);
  // R3: carrier stays within the triangle
  assert_carrier_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    carrier <= period);

  // R5: compare changes only with an event and takes the sampled command
  assert_cmp_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !eventPulse |-> $stable(activeCompare));
  assert_cmp_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    eventPulse |-> activeCompare == $past(compareIn));

  // R6: qualifier branches
  assert_aq_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (activeCompare > carrier) |=> (!preA && preB));
  assert_aq_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (activeCompare < carrier) |=> (preA && !preB));

  // R7: equality keeps the pre-outputs
  assert_aq_equal_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (activeCompare == carrier) |=> $stable(preA));

  // R8: disabled channel freezes
  assert_disable_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> ($stable(carrier) && !eventPulse));

  // R9: complementary pre-outputs
  assert_complementary_R9: assert property (@(posedge clk) disable iff (!rst_n)
    preA != preB);
endmodule

bind symm_pwm_timer symm_pwm_timer_chk #(.PERIOD_W(PERIOD_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .enable        (enable),
  .period        (period),
  .compareIn     (compareIn),
  .carrier       (carrier),
  .activeCompare (activeCompare),
  .eventPulse    (eventPulse),
  .preA          (preA),
  .preB          (preB)
);

// File: tb/symm_pwm_timer_tb.sv
module symm_pwm_timer_tb;
  localparam int PW = 8;
  localparam int SW = 6;
  localparam int NVEC = 6;

  // stimulus table: period, step, first command, mid-run command, cycles
  localparam int VEC_P  [NVEC] = '{10, 10, 16, 7, 21, 40};
  localparam int VEC_S  [NVEC] = '{1,  1,  3,  1, 2,  7};
  localparam int VEC_C0 [NVEC] = '{4,  0,  8,  3, 200, 11};
  localparam int VEC_C1 [NVEC] = '{6,  10, 2,  7, 9,  30};
  localparam int VEC_N  [NVEC] = '{60, 60, 80, 50, 90, 80};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic [PW-1:0] period = 8'd10;
  logic [SW-1:0] step = 6'd1;
  logic [PW-1:0] compareIn = '0;
  logic [PW-1:0] carrier;
  logic [PW-1:0] activeCompare;
  logic eventPulse, preA, preB;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // reference state
  int mAcc, mCmp;
  bit mEvt, mA;

  always #4 clk = ~clk;

  symm_pwm_timer #(.PERIOD_W(PW), .STEP_W(SW)) u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .period(period), .step(step),
    .compareIn(compareIn), .carrier(carrier), .activeCompare(activeCompare),
    .eventPulse(eventPulse), .preA(preA), .preB(preB)
  );

  function automatic int absInt(input int v);
    return (v < 0) ? -v : v;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one clock: update the reference at the edge, then wait for the falling edge
  task automatic tick();
    int car, sum, nxt;
    bit fold, load;
    @(posedge clk);
    if (!rst_n) begin
      mAcc = -int'(period); mCmp = 0; mEvt = 0; mA = 0;
    end else begin
      car = absInt(mAcc);
      if (mCmp > car) mA = 0;
      else if (mCmp < car) mA = 1;
      if (enable) begin
        sum  = mAcc + 2 * int'(step);
        fold = sum > int'(period);
        nxt  = fold ? sum - 2 * int'(period) : sum;
        load = fold || (mAcc < 0 && nxt >= 0);
        mEvt = load;
        if (load) mCmp = int'(compareIn);
        mAcc = nxt;
      end else begin
        mEvt = 0;
      end
    end
    @(negedge clk);
  endtask

  task automatic compareAll();
    check(int'(carrier) == absInt(mAcc), "R2 carrier", carrier, absInt(mAcc));
    check(carrier <= period, "R3 bound", carrier, period);
    check(eventPulse == mEvt, "R4 event", eventPulse, mEvt);
    check(int'(activeCompare) == mCmp, "R5 compare", activeCompare, mCmp);
    check(preA == mA, "R6 preA", preA, mA);
    check(preA != preB, "R9 complement", preB, !preA);
  endtask

  task automatic startRun(input int p, input int s, input int c);
    rst_n = 0; enable = 0;
    period = PW'(p); step = SW'(s); compareIn = PW'(c);
    tick(); tick();
    rst_n = 1; enable = 1;
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int evCount;
    bit seenEq;
    bit savedA;
    int savedCar, savedCmp;

    // R1: reset state
    startRun(10, 1, 5);
    rst_n = 0;
    tick();
    check(carrier == 8'd10, "R1 carrier", carrier, 10);
    check(activeCompare == 8'd0, "R1 compare", activeCompare, 0);
    check(eventPulse == 1'b0, "R1 event", eventPulse, 0);
    check(preA == 1'b0 && preB == 1'b1, "R1 preA/preB", {preA, preB}, 1);

    // table-driven runs with a mid-run command change
    for (int v = 0; v < NVEC; v++) begin
      startRun(VEC_P[v], VEC_S[v], VEC_C0[v]);
      for (int k = 0; k < VEC_N[v]; k++) begin
        if (k == VEC_N[v] / 2) compareIn = PW'(VEC_C1[v]);
        tick();
        compareAll();
      end
    end

    // R2/R4: first cycles after reset with period 10, step 1
    startRun(10, 1, 4);
    tick();
    check(carrier == 8'd8, "R2 first step", carrier, 8);
    evCount = 0;
    for (int k = 0; k < 4; k++) begin
      tick();
      if (eventPulse) evCount++;
    end
    check(carrier == 8'd0 && eventPulse, "R4 valley event", {carrier, eventPulse}, 1);
    check(evCount == 1, "R4 single pulse", evCount, 1);
    tick();
    check(!eventPulse, "R4 pulse one clock", eventPulse, 0);

    // R5: mid-ramp command change is not taken
    compareIn = 8'd9;
    tick();
    check(activeCompare == 8'd4, "R5 no load mid-ramp", activeCompare, 4);

    // R7: equality keeps the pre-outputs (compare 4 against carrier 4)
    startRun(10, 1, 4);
    seenEq = 0;
    for (int k = 0; k < 40 && !seenEq; k++) begin
      tick();
      if (activeCompare == 8'd4 && carrier == 8'd4) seenEq = 1;
    end
    check(seenEq, "R7 equality reached", seenEq, 1);
    savedA = preA;
    tick();
    check(preA == savedA, "R7 hold on equal", preA, savedA);

    // R8: enable low freezes carrier and compare
    startRun(16, 3, 8);
    for (int k = 0; k < 7; k++) tick();
    enable = 0;
    savedCar = carrier;
    savedCmp = activeCompare;
    compareIn = 8'd99;
    for (int k = 0; k < 5; k++) begin
      tick();
      check(int'(carrier) == savedCar, "R8 carrier held", carrier, savedCar);
      check(int'(activeCompare) == savedCmp, "R8 compare held", activeCompare, savedCmp);
      check(!eventPulse, "R8 no event", eventPulse, 0);
    end
    enable = 1;
    for (int k = 0; k < 20; k++) begin
      tick();
      compareAll();
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule